// File: doc/BRIEF.md
# Flash Erase and Program Command Front End

This block sits on the special-function-register bus of an 8-bit microcontroller and turns register writes into requests for an on-chip program flash macro. Software writes a page number into a page register, may set enable bits in a control register, and then writes a key byte into a command register. The block checks that key and its preconditions, and then raises one request toward the flash macro: page erase, mass erase or single-byte program. The request stays up until the macro acknowledges it. Each precondition is used up by the command that consumes it, so software must arm it again before the next command.

External-data store cycles from the core pass through to XRAM. When the program-write enable bit is set, the block takes the next store as a flash byte program instead and then clears the enable bit. A security bit can only be set. Once set it drives an output that blocks external reads of flash and program RAM until chip reset. A command that fails its preconditions raises no request. Instead it sets a sticky error flag, which software clears by writing a one.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset all three registers read 0x00, and busy, request, error and secure outputs are low.
- R2: Register map: command register at SFR address 0x94 always reads 0x00. Page register at 0xB7 reads the page number in bits [7:1], and bit 0 always reads 0. Control register at 0xB2 reads bit 0 program-write enable, bit 1 mass-erase enable, bit 6 secure, bit 7 error, and zeros elsewhere.
- R3: Writing 0x55 to the command register after a page register write raises a request with op code 1 (page erase) and address page × 512, one cycle after the write.
- R4: After a page erase is accepted, a further 0x55 without a new page register write raises no request and sets the error flag.
- R5: Writing 0xAA with mass-erase enable set and the debug-enable input high raises a request with op code 2 (mass erase) and address 0, and clears the mass-erase enable bit.
- R6: A 0xAA write with mass-erase enable clear, or with debug-enable low, raises no request and sets the error flag.
- R7: Writing any value other than 0x55 or 0xAA to the command register raises no request, sets no error, and consumes no armed precondition.
- R8: With program-write enable set, a store raises a request with op code 3 (byte program) carrying the store address and data, does not write XRAM, and clears program-write enable. With the bit clear, a store writes XRAM and raises no request.
- R9: While the interrupt-enable input is high, control writes leave program-write enable unchanged, while the other control bits still take the written value.
- R10: The secure bit is set by writing 1 to control bit 6, ignores writes of 0, and drives the secure output until reset.
- R11: Busy is high from acceptance until the macro acknowledges. While busy, the request's op code and address stay stable, and new commands and flash stores are ignored without setting the error flag.
- R12: Writing 1 to control bit 7 clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for the addressed register |
| irq_en | input | 1 | Global interrupt enable from the core |
| dbg_en | input | 1 | Debug port enabled |
| st_valid | input | 1 | External-data store strobe |
| st_addr | input | 16 | Store address (data pointer) |
| st_data | input | 8 | Store data |
| xram_we | output | 1 | XRAM write enable |
| xram_addr | output | 16 | XRAM write address |
| xram_wdata | output | 8 | XRAM write data |
| fl_req | output | 1 | Flash macro request, held until acknowledged |
| fl_op | output | 2 | Request op: 1 page erase, 2 mass erase, 3 byte program |
| fl_addr | output | 16 | Request address |
| fl_wdata | output | 8 | Program data |
| fl_ack | input | 1 | Flash macro completion pulse |
| busy_o | output | 1 | Command in progress |
| secure_o | output | 1 | Blocks external reads of flash and program RAM |
| err_o | output | 1 | Sticky precondition error |

## Verification
Each command key is applied with its precondition present, then applied again with the precondition used up or missing. This separates accepted commands (a request with the right op and address) from rejected ones (only the error flag moves). Neutral key values are written between an arming write and a real key, which shows whether a wrong value consumes the arming. Stores are issued with program-write enable clear, set, and set while busy, which tells XRAM routing from flash programming from the busy lockout. Control writes under interrupt enable show that only the program-write enable bit is gated.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        FOP_NONE = 2'd0,
        FOP_PAGE = 2'd1,
        FOP_MASS = 2'd2,
        FOP_PROG = 2'd3
    } fop_e;

    localparam int CTL_PWE    = 0;
    localparam int CTL_MEEN   = 1;
    localparam int CTL_SEC    = 6;
    localparam int CTL_ERRCLR = 7;

    localparam logic [7:0] KEY_PAGE = 8'h55;
    localparam logic [7:0] KEY_MASS = 8'hAA;

    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_CMD   = 2'd1,
        RSEL_PAGE  = 2'd2,
        RSEL_CTL   = 2'd3
    } rsel_e;

endpackage

// File: rtl/fcf_sfr_decode.sv
module fcf_sfr_decode
    import flash_cmd_pkg::*;
#(
    parameter logic [7:0] CMD_ADR  = 8'h94,
    parameter logic [7:0] PAGE_ADR = 8'hB7,
    parameter logic [7:0] CTL_ADR  = 8'hB2
) (
    input  logic [7:0] addr,
    input  logic       wr,
    output logic       wr_cmd,
    output logic       wr_page,
    output logic       wr_ctl,
    output rsel_e      rsel
);

    always_comb begin
        rsel = RSEL_NONE;
        if (addr == CMD_ADR)  rsel = RSEL_CMD;
        if (addr == PAGE_ADR) rsel = RSEL_PAGE;
        if (addr == CTL_ADR)  rsel = RSEL_CTL;
    end

    assign wr_cmd  = wr && (rsel == RSEL_CMD);
    assign wr_page = wr && (rsel == RSEL_PAGE);
    assign wr_ctl  = wr && (rsel == RSEL_CTL);

endmodule

// File: rtl/fcf_engine.sv
module fcf_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 7,
    parameter int PAGE_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_page,
    input  logic              wr_ctl,
    input  logic [7:0]        wdata,
    input  logic              irq_en,
    input  logic              dbg_en,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [7:0]        st_data,
    input  logic              fl_ack,
    output logic              fl_req,
    output fop_e              fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic [PAGE_W-1:0] page,
    output logic              pwe,
    output logic              meen,
    output logic              secure,
    output logic              err
);

    typedef struct packed {
        logic              req;
        fop_e              op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [PAGE_W-1:0] page;
        logic              pg_armed;
        logic              pwe;
        logic              meen;
        logic              secure;
        logic              err;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    busy;
    logic    cmd_started;

    always_comb begin
        st_d        = st_q;
        busy        = st_q.req;
        cmd_started = 1'b0;

        if (st_q.req && fl_ack) begin
            st_d.req = 1'b0;
        end

        if (wr_page) begin
            st_d.page     = wdata[7:1];
            st_d.pg_armed = 1'b1;
        end

        if (wr_ctl) begin
            if (!irq_en) begin
                st_d.pwe = wdata[CTL_PWE];
            end
            st_d.meen   = wdata[CTL_MEEN];
            st_d.secure = st_q.secure | wdata[CTL_SEC];
            if (wdata[CTL_ERRCLR]) begin
                st_d.err = 1'b0;
            end
        end

        if (wr_cmd && !busy) begin
            if (wdata == KEY_PAGE) begin
                if (st_q.pg_armed) begin
                    st_d.req      = 1'b1;
                    st_d.op       = FOP_PAGE;
                    st_d.addr     = ADDR_W'(st_q.page) << PAGE_SHIFT;
                    st_d.data     = '0;
                    st_d.pg_armed = 1'b0;
                    cmd_started   = 1'b1;
                end else begin
                    st_d.err = 1'b1;
                end
            end else if (wdata == KEY_MASS) begin
                if (st_q.meen && dbg_en) begin
                    st_d.req    = 1'b1;
                    st_d.op     = FOP_MASS;
                    st_d.addr   = '0;
                    st_d.data   = '0;
                    st_d.meen   = 1'b0;
                    cmd_started = 1'b1;
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end

        if (st_valid && st_q.pwe && !busy && !cmd_started) begin
            st_d.req  = 1'b1;
            st_d.op   = FOP_PROG;
            st_d.addr = st_addr;
            st_d.data = st_data;
            st_d.pwe  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0, op: FOP_NONE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fl_req   = st_q.req;
    assign fl_op    = st_q.op;
    assign fl_addr  = st_q.addr;
    assign fl_wdata = st_q.data;
    assign page     = st_q.page;
    assign pwe      = st_q.pwe;
    assign meen     = st_q.meen;
    assign secure   = st_q.secure;
    assign err      = st_q.err;

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter int         PAGE_SHIFT = 9,
    parameter logic [7:0] CMD_ADR    = 8'h94,
    parameter logic [7:0] PAGE_ADR   = 8'hB7,
    parameter logic [7:0] CTL_ADR    = 8'hB2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic              irq_en,
    input  logic              dbg_en,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [7:0]        st_data,
    output logic              xram_we,
    output logic [ADDR_W-1:0] xram_addr,
    output logic [7:0]        xram_wdata,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic              fl_ack,
    output logic              busy_o,
    output logic              secure_o,
    output logic              err_o
);

    localparam int PAGE_W = 7;

    logic              wr_cmd, wr_page, wr_ctl;
    rsel_e             rsel;
    fop_e              op_w;
    logic [PAGE_W-1:0] page_w;
    logic              pwe_w, meen_w, sec_w, err_w;

    fcf_sfr_decode #(
        .CMD_ADR  (CMD_ADR),
        .PAGE_ADR (PAGE_ADR),
        .CTL_ADR  (CTL_ADR)
    ) u_dec (
        .addr    (sfr_addr),
        .wr      (sfr_wr),
        .wr_cmd  (wr_cmd),
        .wr_page (wr_page),
        .wr_ctl  (wr_ctl),
        .rsel    (rsel)
    );

    fcf_engine #(
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmd   (wr_cmd),
        .wr_page  (wr_page),
        .wr_ctl   (wr_ctl),
        .wdata    (sfr_wdata),
        .irq_en   (irq_en),
        .dbg_en   (dbg_en),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .st_data  (st_data),
        .fl_ack   (fl_ack),
        .fl_req   (fl_req),
        .fl_op    (op_w),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .page     (page_w),
        .pwe      (pwe_w),
        .meen     (meen_w),
        .secure   (sec_w),
        .err      (err_w)
    );

    always_comb begin
        unique case (rsel)
            RSEL_PAGE: sfr_rdata = {page_w, 1'b0};
            RSEL_CTL:  sfr_rdata = {err_w, sec_w, 4'b0000, meen_w, pwe_w};
            default:   sfr_rdata = 8'h00;
        endcase
    end

    assign xram_we    = st_valid && !pwe_w;
    assign xram_addr  = st_addr;
    assign xram_wdata = st_data;
    assign fl_op      = op_w;
    assign busy_o     = fl_req;
    assign secure_o   = sec_w;
    assign err_o      = err_w;

endmodule

// File: rtl/fcf_checker.sv
module fcf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fl_req,
    input logic       fl_ack,
    input logic [1:0] fl_op,
    input logic [15:0] fl_addr,
    input logic       secure_o,
    input logic       err_o,
    input logic       xram_we,
    input logic       pwe_w,
    input logic       dbg_en
);

    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> fl_req);

    a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> $stable(fl_op) && $stable(fl_addr));

    a_r10_secure_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        secure_o |=> secure_o);

    a_r8_pwe_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) && fl_op == 2'd3 |-> !pwe_w);

    a_r8_no_xram_in_flash_mode: assert property (@(posedge clk) disable iff (!rst_n)
        xram_we |-> !pwe_w);

    a_r6_mass_needs_debug: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) && fl_op == 2'd2 |-> $past(dbg_en));

    a_r4_reject_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !$rose(fl_req));

endmodule

bind flash_cmd_front fcf_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_req   (fl_req),
    .fl_ack   (fl_ack),
    .fl_op    (fl_op),
    .fl_addr  (fl_addr),
    .secure_o (secure_o),
    .err_o    (err_o),
    .xram_we  (xram_we),
    .pwe_w    (pwe_w),
    .dbg_en   (dbg_en)
);

// File: tb/test_flash_cmd_front.sv
module test_flash_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        irq_en = 1'b0;
    logic        dbg_en = 1'b0;
    logic        st_valid = 1'b0;
    logic [15:0] st_addr = 16'h0;
    logic [7:0]  st_data = 8'h0;
    logic        xram_we;
    logic [15:0] xram_addr;
    logic [7:0]  xram_wdata;
    logic        fl_req;
    logic [1:0]  fl_op;
    logic [15:0] fl_addr;
    logic [7:0]  fl_wdata;
    logic        fl_ack = 1'b0;
    logic        busy_o, secure_o, err_o;

    localparam logic [7:0] A_CMD = 8'h94, A_PAGE = 8'hB7, A_CTL = 8'hB2;

    always #5 clk = ~clk;

    flash_cmd_front i_flash_cmd_front (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_en(irq_en),
        .dbg_en(dbg_en), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .xram_we(xram_we), .xram_addr(xram_addr),
        .xram_wdata(xram_wdata), .fl_req(fl_req), .fl_op(fl_op),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack),
        .busy_o(busy_o), .secure_o(secure_o), .err_o(err_o)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // flash macro model: records each new request, acknowledges after a delay
    int          nreq = 0;
    logic [1:0]  last_op = 2'd0;
    logic [15:0] last_addr = 16'h0;
    logic [7:0]  last_data = 8'h0;
    logic        req_d = 1'b0;
    bit          hold_ack = 1'b0;
    int          acnt = 0;

    always @(posedge clk) begin
        req_d <= fl_req;
        if (fl_req && !req_d) begin
            nreq      <= nreq + 1;
            last_op   <= fl_op;
            last_addr <= fl_addr;
            last_data <= fl_wdata;
        end
        fl_ack <= 1'b0;
        if (fl_req && !fl_ack && !hold_ack) begin
            if (acnt == 3) begin
                fl_ack <= 1'b1;
                acnt   <= 0;
            end else begin
                acnt <= acnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        sfr_addr = a;
        #1 d = sfr_rdata;
    endtask

    task automatic do_store(input logic [15:0] a, input logic [7:0] d, output logic xwe);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1 xwe = xram_we;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        sfr_read(A_CMD, r);  chk("R1 cmd reg", r, 8'h00);
        sfr_read(A_PAGE, r); chk("R1 page reg", r, 8'h00);
        sfr_read(A_CTL, r);  chk("R1 ctl reg", r, 8'h00);
        chk("R1 outputs busy/req/err/sec", {busy_o, fl_req, err_o, secure_o}, 4'b0000);
    endtask

    task automatic t_page();
        logic [7:0] r;
        int n0;
        sfr_write(A_PAGE, 8'h0B);
        sfr_read(A_PAGE, r); chk("R2 page readback bit0 zero", r, 8'h0A);
        n0 = nreq;
        sfr_write(A_CMD, 8'h55);
        chk("R11 busy after page accept", busy_o, 1'b1);
        chk("R3 request up one cycle after write", fl_req, 1'b1);
        sfr_read(A_CMD, r); chk("R2 cmd reg reads zero", r, 8'h00);
        wait_idle();
        chk("R3 one page request", nreq, n0 + 1);
        chk("R3 page op", last_op, 2'd1);
        chk("R3 page address", last_addr, 16'h0A00);
        chk("R11 busy clear after ack", busy_o, 1'b0);
        sfr_write(A_CMD, 8'h55);
        wait_idle();
        chk("R4 no request without re-arm", nreq, n0 + 1);
        chk("R4 error set", err_o, 1'b1);
        sfr_read(A_CTL, r); chk("R2 error in ctl bit7", r, 8'h80);
        sfr_write(A_CTL, 8'h80);
        chk("R12 error cleared", err_o, 1'b0);
    endtask

    task automatic t_mass();
        logic [7:0] r;
        int n0;
        n0 = nreq;
        dbg_en = 1'b1;
        sfr_write(A_CTL, 8'h02);
        sfr_read(A_CTL, r); chk("R2 meen readback", r, 8'h02);
        sfr_write(A_CMD, 8'hAA);
        wait_idle();
        chk("R5 mass request", nreq, n0 + 1);
        chk("R5 mass op", last_op, 2'd2);
        chk("R5 mass address", last_addr, 16'h0000);
        sfr_read(A_CTL, r); chk("R5 meen cleared", r, 8'h00);
        sfr_write(A_CMD, 8'hAA);
        wait_idle();
        chk("R6 no mass without re-enable", nreq, n0 + 1);
        chk("R6 error without meen", err_o, 1'b1);
        sfr_write(A_CTL, 8'h80);
        dbg_en = 1'b0;
        sfr_write(A_CTL, 8'h02);
        sfr_write(A_CMD, 8'hAA);
        wait_idle();
        chk("R6 no mass with debug off", nreq, n0 + 1);
        chk("R6 error with debug off", err_o, 1'b1);
        sfr_write(A_CTL, 8'h80);
        dbg_en = 1'b1;
    endtask

    task automatic t_other();
        int n0;
        n0 = nreq;
        sfr_write(A_PAGE, 8'h0E);
        sfr_write(A_CMD, 8'h12);
        sfr_write(A_CMD, 8'h00);
        sfr_write(A_CMD, 8'h5A);
        wait_idle();
        chk("R7 other keys no request", nreq, n0);
        chk("R7 other keys no error", err_o, 1'b0);
        sfr_write(A_CMD, 8'h55);
        wait_idle();
        chk("R7 arming kept after other keys", nreq, n0 + 1);
        chk("R7 armed page address", last_addr, 16'h0E00);
    endtask

    task automatic t_prog();
        logic [7:0] r;
        logic xwe;
        int n0;
        n0 = nreq;
        sfr_write(A_CTL, 8'h01);
        sfr_read(A_CTL, r); chk("R8 pwe set", r, 8'h01);
        do_store(16'h1234, 8'h5A, xwe);
        chk("R8 no xram write in flash mode", xwe, 1'b0);
        wait_idle();
        chk("R8 program request", nreq, n0 + 1);
        chk("R8 program op", last_op, 2'd3);
        chk("R8 program address", last_addr, 16'h1234);
        chk("R8 program data", last_data, 8'h5A);
        sfr_read(A_CTL, r); chk("R8 pwe auto-cleared", r, 8'h00);
        do_store(16'h0042, 8'h99, xwe);
        chk("R8 xram write when pwe clear", xwe, 1'b1);
        wait_idle();
        chk("R8 no request for xram store", nreq, n0 + 1);
    endtask

    task automatic t_irq();
        logic [7:0] r;
        irq_en = 1'b1;
        sfr_write(A_CTL, 8'h03);
        sfr_read(A_CTL, r); chk("R9 pwe gated, meen written", r, 8'h02);
        irq_en = 1'b0;
        sfr_write(A_CTL, 8'h01);
        irq_en = 1'b1;
        sfr_write(A_CTL, 8'h00);
        sfr_read(A_CTL, r); chk("R9 pwe clear blocked", r, 8'h01);
        irq_en = 1'b0;
        sfr_write(A_CTL, 8'h00);
        sfr_read(A_CTL, r); chk("R9 pwe clear when irq off", r, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] r;
        logic xwe;
        int n0;
        n0 = nreq;
        hold_ack = 1'b1;
        sfr_write(A_PAGE, 8'h04);
        sfr_write(A_CMD, 8'h55);
        sfr_write(A_PAGE, 8'h06);
        sfr_write(A_CMD, 8'h55);
        sfr_write(A_CTL, 8'h01);
        do_store(16'h2000, 8'h11, xwe);
        chk("R11 store while busy not to xram", xwe, 1'b0);
        repeat (3) @(negedge clk);
        chk("R11 still busy", busy_o, 1'b1);
        chk("R11 no error while busy", err_o, 1'b0);
        sfr_read(A_CTL, r); chk("R11 pwe kept after ignored store", r, 8'h01);
        hold_ack = 1'b0;
        wait_idle();
        chk("R11 only first command issued", nreq, n0 + 1);
        chk("R11 first page address", last_addr, 16'h0400);
        sfr_write(A_CTL, 8'h00);
    endtask

    task automatic t_secure();
        logic [7:0] r;
        sfr_write(A_CTL, 8'h40);
        chk("R10 secure set", secure_o, 1'b1);
        sfr_write(A_CTL, 8'h00);
        chk("R10 secure not cleared", secure_o, 1'b1);
        sfr_read(A_CTL, r); chk("R10 secure readback", r, 8'h40);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page();
        t_mass();
        t_other();
        t_prog();
        t_irq();
        t_busy();
        t_secure();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

endmodule